// File: doc/BRIEF.md
# CAN Interrupt Level and Vector Generator

This block collects the interrupt sources of a CAN controller (sixteen message-buffer flags plus bus-off, error and wake-up). Each source is gated by its own enable bit. When at least one enabled source is pending, the block drives a single programmable request level onto a seven-line interrupt bus.

When the processor starts an acknowledge cycle, the block compares the acknowledged level with its own programmed level. If they match and a source is pending, it enters arbitration. If it wins, it presents an 8-bit vector: a 3-bit programmable base on top and the 5-bit code of the highest-priority pending source below it.

Source flags are level signals owned by external status registers. The block never clears them. Peripheral arbitration is outside the block: the `arb_win_i` input reports its outcome.

Top module: `can_irq_vector_gen`

## Requirements
- R1: A source counts as pending only when both its flag and its enable bit are high. A masked flag has no effect on `irq_o` or on the vector code.
- R2: Priority is fixed, and the lowest code wins. Buffer n has code n (0 to 15), bus-off has code 16, error has code 17 and wake-up has code 18.
- R3: The vector is laid out as follows: bits 7:5 hold the base value captured at acknowledge start, and bits 4:0 hold the captured source code.
- R4: With a nonzero level L and any enabled source pending, `irq_o` has exactly bit L set, in the same cycle. With nothing pending, `irq_o` is all zero.
- R5: A programmed level of 0 keeps every `irq_o` line low.
- R6: `arb_req_o` rises on the clock edge that first sees `iack_i` high. It does so only if, at that edge, `iack_level_i` equals the nonzero programmed level and an enabled source is pending. It then stays high while `iack_i` is high and drops in the same cycle `iack_i` falls.
- R7: `vec_valid_o` is high only while `arb_req_o` and `arb_win_i` are both high. `vec_o` reads zero whenever `vec_valid_o` is low.
- R8: The captured vector stays constant for the whole acknowledge cycle, even if flags, masks or base change during it.
- R9: If no enabled source is pending, or the levels differ, at acknowledge start, the block does not respond for that whole cycle, even if a source becomes pending later in the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_flag_i | input | 16 | Message-buffer interrupt flags |
| buf_en_i | input | 16 | Message-buffer enable bits |
| bus_off_i | input | 1 | Bus-off flag |
| bus_off_en_i | input | 1 | Bus-off enable |
| err_i | input | 1 | Error flag |
| err_en_i | input | 1 | Error enable |
| wake_i | input | 1 | Wake-up flag |
| wake_en_i | input | 1 | Wake-up enable |
| level_i | input | 3 | Programmed request level, 0 = off |
| vec_base_i | input | 3 | Vector base field |
| irq_o | output | 7 | Request lines, bit k = level k, active high |
| iack_i | input | 1 | Acknowledge cycle in progress |
| iack_level_i | input | 3 | Level being acknowledged |
| arb_win_i | input | 1 | Arbitration outcome, high = won |
| arb_req_o | output | 1 | Block takes part in arbitration |
| vec_valid_o | output | 1 | Vector driven |
| vec_o | output | 8 | Interrupt vector |

## Verification
A wrong mask or a wrong priority path shows up at once as a wrong `irq_o` line or a wrong low vector field, in the first acknowledge that follows. If the acknowledge-start capture register fails to hold, `vec_o` changes in the middle of a cycle: a flag toggle one cycle after `iack_i` rises exposes this within that same cycle. A stuck match or hit flag appears as `arb_req_o` asserted on a mismatched level, or still asserted after `iack_i` falls, one edge later.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NUM_BUF_DEF = 16;
  localparam int EXTRA_SRC   = 3;  // bus-off, error, wake-up after the buffers
endpackage

// File: rtl/can_irq_gate.sv
module can_irq_gate #(
  parameter int NUM_BUF = 16,
  localparam int NUM_SRC = NUM_BUF + can_irq_pkg::EXTRA_SRC
) (
  input  logic [NUM_BUF-1:0] buf_flag_i,
  input  logic [NUM_BUF-1:0] buf_en_i,
  input  logic               bus_off_i,
  input  logic               bus_off_en_i,
  input  logic               err_i,
  input  logic               err_en_i,
  input  logic               wake_i,
  input  logic               wake_en_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               any_o
);
  // bit index equals source code
  assign pend_o = {wake_i & wake_en_i, err_i & err_en_i, bus_off_i & bus_off_en_i,
                   buf_flag_i & buf_en_i};
  assign any_o  = |pend_o;
endmodule

// File: rtl/can_irq_prio_enc.sv
module can_irq_prio_enc #(
  parameter int N = 19,
  parameter int W = 5
) (
  input  logic [N-1:0] req_i,
  output logic [W-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = W'(i);
    end
  end
endmodule

// File: rtl/can_irq_level_dec.sv
module can_irq_level_dec #(
  parameter int LVL_W = 3,
  localparam int LINES = (1 << LVL_W) - 1
) (
  input  logic             en_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [LINES:1]   irq_o
);
  always_comb begin
    irq_o = '0;
    for (int k = 1; k <= LINES; k++) begin
      if (en_i && (level_i == LVL_W'(k))) irq_o[k] = 1'b1;
    end
  end
endmodule

// File: rtl/can_irq_ack_ctrl.sv
module can_irq_ack_ctrl #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iack_i,
  input  logic [LVL_W-1:0] iack_level_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             any_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             arb_win_i,
  output logic             arb_req_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             iack_q, hit_q;
  logic [VEC_W-1:0] vec_q;
  logic             start;

  assign start = iack_i & ~iack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iack_q <= 1'b0;
      hit_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      iack_q <= iack_i;
      if (start) begin
        hit_q <= any_i && (level_i != '0) && (iack_level_i == level_i);
        vec_q <= vec_i;
      end else if (!iack_i) begin
        hit_q <= 1'b0;
      end
    end
  end

  assign arb_req_o   = hit_q & iack_i;
  assign vec_valid_o = arb_req_o & arb_win_i;
  assign vec_o       = vec_valid_o ? vec_q : '0;
endmodule

// File: rtl/can_irq_vector_gen.sv
module can_irq_vector_gen #(
  parameter int NUM_BUF = can_irq_pkg::NUM_BUF_DEF,
  parameter int LVL_W   = 3,
  parameter int BASE_W  = 3,
  localparam int NUM_SRC = NUM_BUF + can_irq_pkg::EXTRA_SRC,
  localparam int CODE_W  = $clog2(NUM_SRC),
  localparam int VEC_W   = BASE_W + CODE_W,
  localparam int LINES   = (1 << LVL_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BUF-1:0] buf_flag_i,
  input  logic [NUM_BUF-1:0] buf_en_i,
  input  logic               bus_off_i,
  input  logic               bus_off_en_i,
  input  logic               err_i,
  input  logic               err_en_i,
  input  logic               wake_i,
  input  logic               wake_en_i,
  input  logic [LVL_W-1:0]   level_i,
  input  logic [BASE_W-1:0]  vec_base_i,
  output logic [LINES:1]     irq_o,
  input  logic               iack_i,
  input  logic [LVL_W-1:0]   iack_level_i,
  input  logic               arb_win_i,
  output logic               arb_req_o,
  output logic               vec_valid_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [NUM_SRC-1:0] pend;
  logic               any_pend;
  logic [CODE_W-1:0]  code;

  can_irq_gate #(.NUM_BUF(NUM_BUF)) u_gate (
    .buf_flag_i, .buf_en_i, .bus_off_i, .bus_off_en_i,
    .err_i, .err_en_i, .wake_i, .wake_en_i,
    .pend_o(pend), .any_o(any_pend)
  );

  can_irq_prio_enc #(.N(NUM_SRC), .W(CODE_W)) u_enc (
    .req_i(pend), .code_o(code)
  );

  can_irq_level_dec #(.LVL_W(LVL_W)) u_dec (
    .en_i(any_pend), .level_i, .irq_o
  );

  can_irq_ack_ctrl #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_ack (
    .clk_i, .rst_ni, .iack_i, .iack_level_i, .level_i,
    .any_i(any_pend), .vec_i({vec_base_i, code}), .arb_win_i,
    .arb_req_o, .vec_valid_o, .vec_o
  );
endmodule

// File: rtl/can_irq_vector_gen_chk.sv
module can_irq_vector_gen_chk #(
  parameter int LINES = 7,
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LINES:1]   irq_o,
  input logic [LVL_W-1:0] level_i,
  input logic             any_pend,
  input logic             iack_i,
  input logic             arb_win_i,
  input logic             arb_req_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_o
);
  p_irq_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  p_irq_needs_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> any_pend);
  p_level_zero_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |-> (irq_o == '0));
  p_req_needs_iack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_i |-> !arb_req_o);
  p_no_win_no_vec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arb_req_o && arb_win_i) |-> (!vec_valid_o && vec_o == '0));
  p_vec_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && $past(vec_valid_o)) |-> $stable(vec_o));
endmodule

bind can_irq_vector_gen can_irq_vector_gen_chk #(
  .LINES(LINES), .LVL_W(LVL_W), .VEC_W(VEC_W)
) u_chk (
  .clk_i, .rst_ni, .irq_o, .level_i, .any_pend, .iack_i, .arb_win_i,
  .arb_req_o, .vec_valid_o, .vec_o
);

// File: tb/tb_can_irq_vector_gen.sv
`timescale 1ns/1ps
module tb_can_irq_vector_gen;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [15:0] buf_flag_i = '0, buf_en_i = '0;
  logic        bus_off_i = 0, bus_off_en_i = 0, err_i = 0, err_en_i = 0, wake_i = 0, wake_en_i = 0;
  logic [2:0]  level_i = '0, vec_base_i = '0, iack_level_i = '0;
  logic [7:1]  irq_o;
  logic        iack_i = 0, arb_win_i = 0, arb_req_o, vec_valid_o;
  logic [7:0]  vec_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  can_irq_vector_gen dut (.*);

  function automatic logic [18:0] m_pend();
    return {wake_i & wake_en_i, err_i & err_en_i, bus_off_i & bus_off_en_i, buf_flag_i & buf_en_i};
  endfunction
  function automatic logic [4:0] m_code(logic [18:0] p);
    for (int i = 0; i < 19; i++) if (p[i]) return 5'(i);
    return 5'd0;
  endfunction
  function automatic logic [7:1] m_irq(logic [2:0] lvl, logic any);
    logic [7:1] r = '0;
    if (any && lvl != 0) r[lvl] = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rand_src();
    {buf_flag_i, buf_en_i} = {$urandom, $urandom};
    if ($urandom_range(3) == 0) buf_en_i = '0;
    {bus_off_i, bus_off_en_i, err_i, err_en_i, wake_i, wake_en_i} = 6'($urandom);
    level_i = 3'($urandom); vec_base_i = 3'($urandom);
  endtask

  // full acknowledge cycle, checks R3 R6 R7 R8 R9
  task automatic ack(logic [2:0] lvl, logic win);
    logic [18:0] p = m_pend();
    logic hit = (p != 0) && (level_i != 0) && (lvl == level_i);
    logic [7:0] ev = {vec_base_i, m_code(p)};
    @(negedge clk_i);
    iack_i = 1; iack_level_i = lvl; arb_win_i = win;
    #1 chk("R6 no req before edge", arb_req_o, 0);
    @(negedge clk_i);
    chk(hit ? "R6 req" : "R9 no req", arb_req_o, hit);
    chk("R7 valid", vec_valid_o, hit && win);
    chk("R3 vec", vec_o, (hit && win) ? ev : 8'h00);
    buf_flag_i = ~buf_flag_i; wake_i = ~wake_i; vec_base_i = ~vec_base_i; buf_en_i = '1;
    @(negedge clk_i);
    chk("R8 hold", vec_o, (hit && win) ? ev : 8'h00);
    chk("R9 late pend", arb_req_o, hit);
    iack_i = 0;
    #1 chk("R6 drop", arb_req_o, 0);
    chk("R7 zero", vec_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #12 rst_ni = 1;
    @(negedge clk_i);
    chk("R6 reset", arb_req_o, 0);
    chk("R4 reset", irq_o, 0);
    // R2 directed: wake only -> 18, buf0+wake -> 0, bus-off vs error
    level_i = 3; vec_base_i = 3'b101; wake_i = 1; wake_en_i = 1;
    #1 chk("R4 wake irq", irq_o, 7'b0000100);
    ack(3, 1);
    buf_flag_i = '0; buf_en_i = '0; wake_i = 1;
    buf_flag_i[0] = 1; buf_en_i[0] = 1;
    ack(3, 1);
    buf_flag_i = '0; buf_en_i = '0; wake_i = 1; err_i = 1; err_en_i = 1; bus_off_i = 1; bus_off_en_i = 1;
    ack(3, 1);
    // R1: masked flags ignored
    buf_flag_i = '1; buf_en_i = '0; bus_off_en_i = 0; err_en_i = 0; wake_en_i = 0;
    #1 chk("R1 masked irq", irq_o, 0);
    ack(3, 1);
    // R5: level zero
    buf_en_i = 16'h0100; level_i = 0;
    #1 chk("R5 level0", irq_o, 0);
    ack(0, 1);
    // R6 mismatch, R7 lose
    level_i = 7; ack(6, 1); ack(7, 0); ack(7, 1);
    // random
    for (int n = 0; n < 300; n++) begin
      @(negedge clk_i);
      rand_src();
      #1 chk("R4 irq", irq_o, m_irq(level_i, m_pend() != 0));
      ack(($urandom_range(3) == 0) ? 3'($urandom) : level_i, 1'($urandom_range(3) != 0));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk_i); tests++; fails++; $display("FAIL watchdog act=timeout exp=done"); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule